// File: doc/BRIEF.md
# Scan Chain with Shadow-Flop Cells

This block is a register of configurable width that doubles as a serial scan chain. A per-position elaboration parameter picks one of three cell kinds for every bit.

- A multiplexed-input cell steers its single flop between the serial chain and the functional input.
- A shadow cell keeps the functional capture path free of any multiplexer. Its main flop always samples the functional input. A second flop (the shadow) carries scan shifting, and a select after the flops decides which of the two drives the cell's outputs.
- A non-scan cell is a plain flop that the chain passes straight through, for partial scan around bits that cannot be changed.

Shadow cells are meant for flops that end timing-critical paths. Non-scan cells are meant for flops that both start and end such paths. All other flops stay multiplexed-input cells.

In test, a pattern is shifted in with scan enable and shadow select both high. The shifted bits appear at the functional outputs as stimulus for the downstream logic. One clock with scan enable low and shadow select still high captures the logic's response into every scan cell. A further shift brings the response out serially. In mission mode both controls are low and the block behaves as an ordinary register.

Top module: `scan_shadow_chain`

## Requirements
- R1: Parameter `KINDS` holds two bits per position, with position i at bits [2i+1:2i]. The codes are: 0 = multiplexed-input cell, 1 = shadow cell, 2 = non-scan cell. The chain runs from the lowest scan position to the highest and skips non-scan positions. `scanIn` enters the lowest scan position, and `scanOut` shows the highest scan position's chain output.
- R2: With `scanEn` = 1 and `shadowSel` = 1, each clock moves every scan cell's value one scan position toward `scanOut`. The lowest scan position takes `scanIn`.
- R3: The main flop of a shadow cell samples its `funcIn` bit on every clock, whatever `scanEn` is.
- R4: The shadow flop of a shadow cell takes its chain input when `scanEn` = 1, and its `funcIn` bit when `scanEn` = 0.
- R5: A shadow cell drives both its `funcOut` bit and its chain output from the shadow flop when `shadowSel` = 1, and from the main flop when `shadowSel` = 0.
- R6: A multiplexed-input cell loads its chain input when `scanEn` = 1 and its `funcIn` bit when `scanEn` = 0. Its `funcOut` bit is its flop, and `shadowSel` has no effect on it.
- R7: A non-scan cell samples its `funcIn` bit on every clock, shifting included.
- R8: With `scanEn` = 0 and `shadowSel` = 0, `funcOut` equals the `funcIn` of the previous clock on every bit.
- R9: `rstN` low clears every flop at once, without waiting for a clock, so `funcOut` and `scanOut` read 0.
- R10: After a pattern is shifted in, one clock with `scanEn` = 0 and `shadowSel` = 1 loads every cell with the `funcIn` produced from that pattern. The next shifts present those values at `scanOut`, highest scan position first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| funcIn | input | WIDTH | Functional next-state data |
| scanIn | input | 1 | Serial chain input |
| scanEn | input | 1 | 1 = shift, 0 = functional capture |
| shadowSel | input | 1 | 1 = shadow cells present their shadow flop |
| funcOut | output | WIDTH | Functional register output |
| scanOut | output | 1 | Serial chain output |

## Verification
The hardest situation to reach is a capture in which the stimulus at the outputs comes from shadow flops while the main flops of the same cells hold unrelated data. Only then does a swapped select or a shadow path that reads the wrong source give a wrong response. The bench reaches it in two steps. First it ties `funcIn` to a nonlinear function of `funcOut`, so the captured response depends on exactly which flop each cell presents. Then it shifts random patterns while holding an unrelated `funcIn`, so the main flops diverge from the shadows before each capture.

// File: rtl/scan_shadow_pkg.sv
package scan_shadow_pkg;

  typedef enum logic [1:0] {
    CELL_MUX    = 2'd0,
    CELL_SHADOW = 2'd1,
    CELL_NOSCAN = 2'd2
  } cell_kind_e;

  typedef struct packed {
    logic shiftEn;     // chain path selected at the scan flop
    logic showShadow;  // shadow flop drives the cell outputs
  } scan_strobe_t;

endpackage

// File: rtl/scan_shadow_ctrl.sv
module scan_shadow_ctrl
  import scan_shadow_pkg::*;
(
  input  logic         scanEn,
  input  logic         shadowSel,
  output scan_strobe_t strb
);

  always_comb begin
    strb.shiftEn    = scanEn;
    strb.showShadow = shadowSel;
  end

endmodule

// File: rtl/scan_shadow_cell.sv
module scan_shadow_cell
  import scan_shadow_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_MUX
) (
  input  logic         clk,
  input  logic         rstN,
  input  scan_strobe_t strb,
  input  logic         funcD,
  input  logic         chainIn,
  output logic         cellQ,
  output logic         chainOut
);

  generate
    if (KIND == CELL_SHADOW) begin : g_shadow
      logic mainQ;
      logic shadowQ;

      // main flop: functional D only, no multiplexer
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mainQ <= 1'b0;
        else       mainQ <= funcD;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shadowQ <= 1'b0;
        else       shadowQ <= strb.shiftEn ? chainIn : funcD;
      end

      assign cellQ    = strb.showShadow ? shadowQ : mainQ;
      assign chainOut = cellQ;

      // R3
      main_tracks_func_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> mainQ == $past(funcD));
      // R4
      shadow_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(strb.shiftEn)) |-> shadowQ == $past(chainIn));
      // R4
      shadow_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(strb.shiftEn)) |-> shadowQ == $past(funcD));
    end else if (KIND == CELL_NOSCAN) begin : g_noscan
      logic mainQ;
      logic unusedStrb;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mainQ <= 1'b0;
        else       mainQ <= funcD;
      end

      assign unusedStrb = ^strb;
      assign cellQ      = mainQ;
      assign chainOut   = chainIn;

      // R7
      noscan_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> cellQ == $past(funcD));
    end else begin : g_mux
      logic mainQ;
      logic unusedSel;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mainQ <= 1'b0;
        else       mainQ <= strb.shiftEn ? chainIn : funcD;
      end

      assign unusedSel = strb.showShadow;
      assign cellQ     = mainQ;
      assign chainOut  = mainQ;

      // R6
      mux_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(strb.shiftEn)) |-> cellQ == $past(chainIn));
      // R6
      mux_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(strb.shiftEn)) |-> cellQ == $past(funcD));
    end
  endgenerate

endmodule

// File: rtl/scan_shadow_datapath.sv
module scan_shadow_datapath
  import scan_shadow_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [2*WIDTH-1:0] KINDS = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  scan_strobe_t     strb,
  input  logic [WIDTH-1:0] dataD,
  input  logic             chainHead,
  output logic [WIDTH-1:0] dataQ,
  output logic             chainTail
);

  localparam int LINKS = WIDTH + 1;

  // link[i] feeds position i; non-scan cells pass it on unchanged
  logic [LINKS-1:0] link;

  assign link[0] = chainHead;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      localparam cell_kind_e K = cell_kind_e'(KINDS[2*i +: 2]);
      scan_shadow_cell #(.KIND(K)) u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .strb    (strb),
        .funcD   (dataD[i]),
        .chainIn (link[i]),
        .cellQ   (dataQ[i]),
        .chainOut(link[i+1])
      );
    end
  endgenerate

  assign chainTail = link[LINKS-1];

  // R8
  mission_register_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.shiftEn) && !strb.showShadow) |-> dataQ == $past(dataD));

endmodule

// File: rtl/scan_shadow_chain.sv
module scan_shadow_chain
  import scan_shadow_pkg::*;
#(
  parameter int                 WIDTH = 8,
  parameter logic [2*WIDTH-1:0] KINDS = 16'h9064
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] funcIn,
  input  logic             scanIn,
  input  logic             scanEn,
  input  logic             shadowSel,
  output logic [WIDTH-1:0] funcOut,
  output logic             scanOut
);

  scan_strobe_t strb;

  scan_shadow_ctrl u_ctrl (
    .scanEn   (scanEn),
    .shadowSel(shadowSel),
    .strb     (strb)
  );

  scan_shadow_datapath #(.WIDTH(WIDTH), .KINDS(KINDS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataD    (funcIn),
    .chainHead(scanIn),
    .dataQ    (funcOut),
    .chainTail(scanOut)
  );

endmodule

// File: tb/scan_shadow_chain_tb.sv
module scan_shadow_chain_tb;

  // default map: mux at 0,4,5; shadow at 1,3,6; non-scan at 2,7 (R1)
  localparam int NSCAN = 6;
  localparam int SCANPOS [NSCAN] = '{0, 1, 3, 4, 5, 6};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] funcIn;
  logic [7:0] funcDrive = 8'h00;
  logic       loopMode = 1'b0;
  logic       scanIn = 1'b0;
  logic       scanEn = 1'b0;
  logic       shadowSel = 1'b0;
  logic [7:0] funcOut;
  logic       scanOut;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [7:0] nextState(input logic [7:0] x);
    return {x[6:0], x[7]} ^ ({x[3:0], x[7:4]} & 8'h3C) ^ 8'hA5;
  endfunction

  assign funcIn = loopMode ? nextState(funcOut) : funcDrive;

  scan_shadow_chain u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .funcIn   (funcIn),
    .scanIn   (scanIn),
    .scanEn   (scanEn),
    .shadowSel(shadowSel),
    .funcOut  (funcOut),
    .scanOut  (scanOut)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] prev, exp, mask, pat;
    void'($urandom(32'h5CA7_0042));

    // R9: reset state
    funcDrive = 8'hFF;
    tick(); tick();
    check(funcOut == 8'h00, "R9 reset funcOut", funcOut, 8'h00);
    check(scanOut == 1'b0, "R9 reset scanOut", {7'b0, scanOut}, 8'h00);
    rstN = 1'b1;

    // R8 mission mode with random functional data
    for (int n = 0; n < 20; n++) begin
      prev = 8'($urandom);
      funcDrive = prev;
      tick();
      check(funcOut == prev, "R8 mission random", funcOut, prev);
    end
    // R8 mission as a closed-loop state register
    loopMode = 1'b1;
    for (int n = 0; n < 10; n++) begin
      exp = nextState(funcOut);
      tick();
      check(funcOut == exp, "R8 mission loop", funcOut, exp);
    end
    loopMode = 1'b0;

    for (int round = 0; round < 25; round++) begin
      pat = (round == 0) ? 8'h3F : (round == 1) ? 8'h00 : (round == 2) ? 8'h15 : 8'($urandom);
      funcDrive = (round == 1) ? 8'hFF : 8'($urandom);
      // shift in pat[0] first (R2)
      scanEn = 1'b1;
      shadowSel = 1'b1;
      for (int j = 0; j < NSCAN; j++) begin
        scanIn = pat[j];
        tick();
      end
      exp = funcDrive;
      mask = 8'h00;
      for (int k = 0; k < NSCAN; k++) begin
        exp[SCANPOS[k]] = pat[NSCAN-1-k];
        mask[SCANPOS[k]] = 1'b1;
      end
      check((funcOut & mask) == (exp & mask), "R2 shifted pattern", funcOut & mask, exp & mask);
      check((funcOut & ~mask) == (funcDrive & ~mask), "R7 non-scan during shift", funcOut & ~mask, funcDrive & ~mask);
      check(scanOut == pat[0], "R1 scanOut from highest scan cell", {7'b0, scanOut}, {7'b0, pat[0]});

      // R5/R3/R6: main flops of shadow cells hold funcIn; mux cells ignore shadowSel
      shadowSel = 1'b0;
      #1;
      check((funcOut & 8'h4A) == (funcDrive & 8'h4A), "R3 R5 main flops visible", funcOut & 8'h4A, funcDrive & 8'h4A);
      check((funcOut & 8'h31) == (exp & 8'h31), "R6 shadowSel no effect", funcOut & 8'h31, exp & 8'h31);
      shadowSel = 1'b1;
      #1;
      check(funcOut == exp, "R5 shadow flops visible", funcOut, exp);

      // capture: response of downstream logic to the launched stimulus (R10, R4)
      loopMode = 1'b1;
      scanEn = 1'b0;
      #1;
      exp = nextState(funcOut);
      tick();
      check(funcOut == exp, "R10 R4 capture response", funcOut, exp);
      loopMode = 1'b0;
      funcDrive = 8'($urandom);

      // unload, highest scan position first (R10, R1)
      scanEn = 1'b1;
      scanIn = 1'b0;
      #1;
      for (int k = NSCAN - 1; k >= 0; k--) begin
        check(scanOut == exp[SCANPOS[k]], "R10 unload bit", {7'b0, scanOut}, {7'b0, exp[SCANPOS[k]]});
        tick();
      end
      scanEn = 1'b0;
      shadowSel = 1'b0;
    end

    // R9: asynchronous reset mid-operation
    funcDrive = 8'hFF;
    tick();
    shadowSel = 1'b1;
    rstN = 1'b0;
    #1;
    check(funcOut == 8'h00, "R9 async clear funcOut", funcOut, 8'h00);
    check(scanOut == 1'b0, "R9 async clear scanOut", {7'b0, scanOut}, 8'h00);
    tick();
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule